// File: doc/BRIEF.md
# Two-Wire Open-Drain Line Controller

This block decides, each cycle, whether the serial data line (SDA) and the serial clock line (SCL) of a two-wire serial port are pulled low or released. It sits between the port's control bits and the pads. Its inputs are the wire mode, the per-line direction and port bits, the data-register output bit, a counter overflow pulse, two write-one-to-clear strobes and the sampled line levels. It drives open-drain pull-low enables, a pull-up disable and two sticky status flags. The shift register and bit counter live elsewhere. Only their output bit and overflow pulse come into this block.

A start detector watches the sampled lines. When it sees SDA fall while SCL is high, it sets a start flag. While that flag is set, SCL is stretched low. In the overflow-hold mode, a counter overflow also stretches SCL low until its own flag is cleared. This lets slow software answer the bus before the next clock pulse goes out. All ports are plain control and status signals. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `twowire_pin_ctrl`

## Requirements
- R1: `sda_pull_low` is 1 in the same cycle exactly when `wire_mode[1]`=1, `sda_dir`=1, and either `shreg_msb`=0 or `sda_port`=0. Otherwise it is 0.
- R2: `scl_pull_low` is 1 in the same cycle exactly when `wire_mode[1]`=1, `scl_dir`=1, and either `scl_port`=0 or an SCL hold (R4, R5) is active. Otherwise it is 0.
- R3: With `wire_mode[1]`=1, a clock edge at which the previous sample of `sda_in` was 1, the current `sda_in` is 0 and `scl_in` is 1 sets `start_flag` after that edge. The flag stays set until it is cleared. With `scl_in`=0 the same SDA edge sets nothing.
- R4: While `start_flag`=1 and `wire_mode[1]`=1, SCL is held, so `scl_pull_low`=1 whenever `scl_dir`=1, even with `scl_port`=1.
- R5: A 1 on `cnt_ovf` sets `ovf_flag` after the next edge in every mode. `ovf_flag` holds SCL only in mode 11 (`wire_mode`=2'b11). In mode 10 it has no effect on `scl_pull_low`.
- R6: A 1 on `clr_start` or `clr_ovf` clears the matching flag at the next edge and ends its hold after that edge. If a set and a clear arrive in the same cycle, the set wins.
- R7: In modes 00 and 01 neither line is pulled low, no start is detected, and a set `ovf_flag` holds nothing.
- R8: `pullup_off` is 1 exactly when `wire_mode[1]`=1.
- R9: After reset both flags are 0. The first edge after reset never reports a start, because the previous SDA sample resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wire_mode | input | 2 | 00 off, 01 three-wire, 10 two-wire, 11 two-wire with overflow hold |
| sda_dir | input | 1 | SDA driver enable (direction bit) |
| scl_dir | input | 1 | SCL driver enable (direction bit) |
| sda_port | input | 1 | SDA port bit, 0 pulls low |
| scl_port | input | 1 | SCL port bit, 0 pulls low |
| shreg_msb | input | 1 | Data-register output bit, 0 pulls SDA low |
| cnt_ovf | input | 1 | Counter overflow pulse |
| clr_start | input | 1 | Write-one strobe that clears the start flag |
| clr_ovf | input | 1 | Write-one strobe that clears the overflow flag |
| sda_in | input | 1 | Sampled SDA level |
| scl_in | input | 1 | Sampled SCL level |
| sda_pull_low | output | 1 | Open-drain pull-low enable for SDA |
| scl_pull_low | output | 1 | Open-drain pull-low enable for SCL |
| start_flag | output | 1 | Sticky start-condition flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| pullup_off | output | 1 | Disables the pad pull-ups |

## Verification
The bench drives an SDA fall with SCL low; a detector that ignores SCL would set the start flag there. It also holds SDA low after clearing the start flag; a level-sensitive detector would set the flag again at once. It pulses overflow in mode 10 and then switches to 11; a design that applies the overflow hold in both modes would stretch SCL too early. Same-cycle set and clear, an SDA fall on the very first edge after reset, and start edges in modes 00/01 catch a dropped event, a false start from the reset value, and a detector left running outside the two-wire modes.

// File: rtl/twi_pin_pkg.sv
package twi_pin_pkg;
  typedef enum logic [1:0] {
    WM_OFF     = 2'b00,
    WM_THREE   = 2'b01,
    WM_TWO     = 2'b10,
    WM_TWO_OVF = 2'b11
  } wire_mode_e;

  function automatic logic is_two_wire(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic ovf_holds(input logic [1:0] m);
    return m == WM_TWO_OVF;
  endfunction
endpackage

// File: rtl/twi_start_det.sv
module twi_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sda_in,
  input  logic scl_in,
  output logic start_evt
);
  // previous SDA sample; reset to 0 so the first edge cannot look like a fall
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev <= 1'b0;
    else        sda_prev <= sda_in;
  end

  assign start_evt = enable & sda_prev & ~sda_in & scl_in;
endmodule

// File: rtl/twi_sticky_flag.sv
module twi_sticky_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb begin
        flag_d = flag_o;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
      end
    end else begin : g_clr_wins
      always_comb begin
        flag_d = flag_o;
        if (set_i) flag_d = 1'b1;
        if (clr_i) flag_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_d;
  end
endmodule

// File: rtl/twi_od_drive.sv
module twi_od_drive
  import twi_pin_pkg::*;
(
  input  logic [1:0] wire_mode,
  input  logic       sda_dir,
  input  logic       scl_dir,
  input  logic       sda_port,
  input  logic       scl_port,
  input  logic       shreg_msb,
  input  logic       start_hold,
  input  logic       ovf_flag,
  output logic       sda_pull_low,
  output logic       scl_pull_low,
  output logic       pullup_off
);
  logic tw;
  logic scl_hold;

  always_comb begin
    tw           = is_two_wire(wire_mode);
    scl_hold     = (tw & start_hold) | (ovf_holds(wire_mode) & ovf_flag);
    sda_pull_low = tw & sda_dir & (~shreg_msb | ~sda_port);
    scl_pull_low = tw & scl_dir & (~scl_port | scl_hold);
    pullup_off   = tw;
  end
endmodule

// File: rtl/twowire_pin_ctrl.sv
module twowire_pin_ctrl
  import twi_pin_pkg::*;
#(
  parameter bit SET_WINS = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wire_mode,
  input  logic       sda_dir,
  input  logic       scl_dir,
  input  logic       sda_port,
  input  logic       scl_port,
  input  logic       shreg_msb,
  input  logic       cnt_ovf,
  input  logic       clr_start,
  input  logic       clr_ovf,
  input  logic       sda_in,
  input  logic       scl_in,
  output logic       sda_pull_low,
  output logic       scl_pull_low,
  output logic       start_flag,
  output logic       ovf_flag,
  output logic       pullup_off
);
  localparam int NFLAG = 2;

  logic             start_evt;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] flag_v;

  twi_start_det u_start_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (is_two_wire(wire_mode)),
    .sda_in   (sda_in),
    .scl_in   (scl_in),
    .start_evt(start_evt)
  );

  assign set_v = {cnt_ovf, start_evt};
  assign clr_v = {clr_ovf, clr_start};

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      twi_sticky_flag #(.SET_WINS(SET_WINS)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v[i]),
        .clr_i (clr_v[i]),
        .flag_o(flag_v[i])
      );
    end
  endgenerate

  assign start_flag = flag_v[0];
  assign ovf_flag   = flag_v[1];

  twi_od_drive u_drive (
    .wire_mode   (wire_mode),
    .sda_dir     (sda_dir),
    .scl_dir     (scl_dir),
    .sda_port    (sda_port),
    .scl_port    (scl_port),
    .shreg_msb   (shreg_msb),
    .start_hold  (start_flag),
    .ovf_flag    (ovf_flag),
    .sda_pull_low(sda_pull_low),
    .scl_pull_low(scl_pull_low),
    .pullup_off  (pullup_off)
  );
endmodule

// File: rtl/twowire_pin_ctrl_chk.sv
module twowire_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] wire_mode,
  input logic       scl_dir,
  input logic       sda_dir,
  input logic       cnt_ovf,
  input logic       clr_start,
  input logic       clr_ovf,
  input logic       sda_in,
  input logic       scl_in,
  input logic       sda_pull_low,
  input logic       scl_pull_low,
  input logic       start_flag,
  input logic       ovf_flag
);
  // R1
  sda_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> (wire_mode[1] && sda_dir));

  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_flag) |-> $past(wire_mode[1] && scl_in && !sda_in));

  // R4
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_mode[1] && start_flag && scl_dir) |-> scl_pull_low);

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_mode == 2'b11 && ovf_flag && scl_dir) |-> scl_pull_low);

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ovf |=> ovf_flag);

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_flag) |-> $past(clr_start));

  // R6
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !cnt_ovf) |=> !ovf_flag);

  // R7
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wire_mode[1] |-> (!sda_pull_low && !scl_pull_low));
endmodule

bind twowire_pin_ctrl twowire_pin_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wire_mode   (wire_mode),
  .scl_dir     (scl_dir),
  .sda_dir     (sda_dir),
  .cnt_ovf     (cnt_ovf),
  .clr_start   (clr_start),
  .clr_ovf     (clr_ovf),
  .sda_in      (sda_in),
  .scl_in      (scl_in),
  .sda_pull_low(sda_pull_low),
  .scl_pull_low(scl_pull_low),
  .start_flag  (start_flag),
  .ovf_flag    (ovf_flag)
);

// File: tb/twowire_pin_ctrl_bench.sv
`timescale 1ns/1ps
module twowire_pin_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wire_mode = 2'b00;
  logic sda_dir = 0, scl_dir = 0, sda_port = 1, scl_port = 1, shreg_msb = 1;
  logic cnt_ovf = 0, clr_start = 0, clr_ovf = 0, sda_in = 1, scl_in = 1;
  logic sda_pull_low, scl_pull_low, start_flag, ovf_flag, pullup_off;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twowire_pin_ctrl u_twowire_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .wire_mode(wire_mode),
    .sda_dir(sda_dir), .scl_dir(scl_dir), .sda_port(sda_port),
    .scl_port(scl_port), .shreg_msb(shreg_msb), .cnt_ovf(cnt_ovf),
    .clr_start(clr_start), .clr_ovf(clr_ovf), .sda_in(sda_in),
    .scl_in(scl_in), .sda_pull_low(sda_pull_low),
    .scl_pull_low(scl_pull_low), .start_flag(start_flag),
    .ovf_flag(ovf_flag), .pullup_off(pullup_off)
  );

  // {mode[1:0], sda_dir, scl_dir, sda_port, scl_port, msb, exp_sda, exp_scl, exp_pu}
  localparam int NVEC = 10;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b10_1_1_1_1_1_0_0_1,
    10'b10_1_1_1_1_0_1_0_1,
    10'b10_1_1_0_1_1_1_0_1,
    10'b10_1_1_1_0_1_0_1_1,
    10'b10_0_0_0_0_0_0_0_1,
    10'b11_1_0_1_0_0_1_0_1,
    10'b11_0_1_0_0_1_0_1_1,
    10'b00_1_1_0_0_0_0_0_0,
    10'b01_1_1_0_0_0_0_0_0,
    10'b11_1_1_1_1_1_0_0_1
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // one clock edge, then settle
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R9 reset state, SDA falling right at release must not count as start
    wire_mode = 2'b10; scl_dir = 1; sda_dir = 1;
    #20;
    check("R9 start_flag in reset", start_flag, 1'b0);
    check("R9 ovf_flag in reset", ovf_flag, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    sda_in = 1'b0;
    tick();
    check("R9 no start on first edge", start_flag, 1'b0);
    sda_in = 1'b1;
    tick();

    // R1 R2 R7 R8 vector table (flags clear)
    for (int i = 0; i < NVEC; i++) begin
      {wire_mode, sda_dir, scl_dir, sda_port, scl_port, shreg_msb} = VEC[i][9:3];
      #1;
      check($sformatf("R1 vec%0d sda", i), sda_pull_low, VEC[i][2]);
      check($sformatf("R2 vec%0d scl", i), scl_pull_low, VEC[i][1]);
      check($sformatf("R8 vec%0d pullup", i), pullup_off, VEC[i][0]);
    end

    // R3 R4: start in mode 10 with SCL high holds SCL low
    wire_mode = 2'b10; sda_dir = 1; scl_dir = 1; sda_port = 1; scl_port = 1; shreg_msb = 1;
    scl_in = 1; sda_in = 1;
    tick();
    sda_in = 0;
    tick();
    check("R3 start detected", start_flag, 1'b1);
    check("R4 scl held by start", scl_pull_low, 1'b1);
    tick();
    check("R3 start sticky", start_flag, 1'b1);

    // R6: clear releases, SDA kept low does not retrigger
    clr_start = 1;
    tick();
    clr_start = 0;
    check("R6 start cleared", start_flag, 1'b0);
    check("R6 scl released", scl_pull_low, 1'b0);
    tick();
    check("R3 no retrigger on low level", start_flag, 1'b0);

    // R3: SDA fall with SCL low is no start
    sda_in = 1; tick();
    scl_in = 0; sda_in = 0; tick();
    check("R3 no start with scl low", start_flag, 1'b0);

    // R7: SDA fall in modes 00 and 01 is no start
    scl_in = 1;
    for (int m = 0; m < 2; m++) begin
      wire_mode = 2'(m);
      sda_in = 1; tick();
      sda_in = 0; tick();
      check($sformatf("R7 no start mode %0d", m), start_flag, 1'b0);
    end

    // R5: overflow in mode 10 sets flag without hold, mode 11 holds
    wire_mode = 2'b10; sda_in = 1;
    cnt_ovf = 1; tick(); cnt_ovf = 0;
    check("R5 ovf flag set", ovf_flag, 1'b1);
    check("R5 no hold in mode 10", scl_pull_low, 1'b0);
    wire_mode = 2'b11; #1;
    check("R5 hold in mode 11", scl_pull_low, 1'b1);
    clr_ovf = 1; tick(); clr_ovf = 0;
    check("R6 ovf cleared", ovf_flag, 1'b0);
    check("R6 ovf hold released", scl_pull_low, 1'b0);

    // R6: set and clear together, set wins
    cnt_ovf = 1; clr_ovf = 1; tick(); cnt_ovf = 0; clr_ovf = 0;
    check("R6 set wins over clear", ovf_flag, 1'b1);
    clr_ovf = 1; tick(); clr_ovf = 0;

    // R5 R7: overflow in mode 00 sets flag but holds nothing
    wire_mode = 2'b00;
    cnt_ovf = 1; tick(); cnt_ovf = 0;
    check("R5 ovf flag set in mode 00", ovf_flag, 1'b1);
    check("R7 no scl pull in mode 00", scl_pull_low, 1'b0);

    // R4: start hold masked by scl_dir=0
    wire_mode = 2'b10; clr_ovf = 1; sda_in = 1; tick(); clr_ovf = 0;
    sda_in = 0; tick();
    scl_dir = 0; #1;
    check("R4 start flag set", start_flag, 1'b1);
    check("R2 hold needs scl_dir", scl_pull_low, 1'b0);

    finish_run();
  end
endmodule